// File: doc/BRIEF.md
# Millisecond Interval Timer Bank

This block holds eight independent periodic timers behind a small byte-wide register port. A shared prescaler divides the system clock down to a one-cycle millisecond strobe. Each timer counts these strobes against its own 32-bit interval. When the count reaches the interval, the timer raises a done flag, adds one to a saturating expiration counter, reloads, and keeps running.

Software programs intervals and per-timer interrupt enables through the register port. It acknowledges expirations by writing ones to a clear register. That register keeps whatever was last written to it, but every write of a 1 acts as a fresh clear. A single interrupt line reports whether any enabled timer has a pending flag. Reads are registered: the data appears on the cycle after the read strobe and holds until the next read.

Top module: `ms_timer_bank`

## Requirements
- R1: After reset, the enable, clear and flag registers, every interval byte and every expiration count read 0, and `irq` is 0.
- R2: Register map (bit n of a per-timer register belongs to timer n+1):
    - 0x07: interrupt enable.
    - 0x08: clear.
    - 0x09: flags.
    - 0x0A+4n to 0x0D+4n: interval of timer n+1. The lowest of the four addresses holds bits [31:24] and the highest holds bits [7:0].
    - 0x2A+n: 8-bit expiration count of timer n+1.
    - Every other address reads 0.
- R3: The millisecond strobe fires once every TICK_DIV clocks, on clock edge k*TICK_DIV after reset is released. A timer whose counter is at 0 and whose interval becomes N>0 sets its flag on the N-th strobe after that point.
- R4: A timer with a nonzero interval N reloads on expiration and expires again every N strobes. Its expiration count increases by one each time.
- R5: The expiration count saturates at 255.
- R6: A timer with interval 0 stays idle: its flag does not set and its count does not change.
- R7: Writing the clear register clears the flag and the count of every timer whose data bit is 1, whether or not that bit already held 1. Bits written 0 have no effect. The register reads back the last value written.
- R8: If a clear and an expiration of the same timer meet on one clock edge, the expiration wins: the flag is 1 and the count is 1 afterwards.
- R9: `irq` is the OR over all timers of (flag AND enable). It follows a write to the enable or clear register on the next clock cycle.
- R10: The flag register is read-only. Writes to it, and writes to unmapped addresses, change nothing.
- R11: `rd_data` is updated on the clock edge that samples `rd_en` high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Combined interrupt of enabled, expired timers |

## Verification
A wrong tick phase or a wrong reload value shows up as a flag that rises one strobe early or late, or as an expiration count that drifts from the number of elapsed intervals. Both are visible at the register port within one interval. Reads are placed two clocks after a strobe boundary, so an off-by-one counter is seen on the first read after the expected expiration. A clear that leaves state behind, or that loses a race with an expiration, shows on `irq` one cycle later and on the next flag or count read.

// File: rtl/mstb_pkg.sv
// Package: shared register map constants and types for the timer bank.
// Assumes a byte-wide register port; addresses are compared as integers.
package mstb_pkg;
    typedef logic [7:0] reg_byte_t;

    localparam int ADDR_EN   = 'h07;
    localparam int ADDR_CLR  = 'h08;
    localparam int ADDR_FLAG = 'h09;
    localparam int IVL_BASE  = 'h0A;
    localparam int BYTE_W    = 8;
endpackage

// File: rtl/mstb_prescaler.sv
// Module: mstb_prescaler
// Divides the system clock into a one-cycle strobe every TICK_DIV cycles.
// Assumes TICK_DIV >= 2. The strobe is high while the counter holds its last value.
module mstb_prescaler #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = $clog2(TICK_DIV);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == LAST);

    // Wrapping divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + DIV_W'(1);
    end

    // R3: the strobe lasts a single cycle.
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/mstb_channel.sv
// Module: mstb_channel
// One interval timer. It stores its interval (written one byte at a time), counts
// strobes, and keeps a done flag and a saturating expiration count.
// Assumes IVL_W is a multiple of 8. Byte 0 is the most significant byte.
module mstb_channel #(
    parameter int IVL_W = 32,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               clr,
    input  logic [IVL_W/8-1:0] byte_we,
    input  logic [7:0]         wdata,
    output logic [IVL_W-1:0]   interval,
    output logic               flag,
    output logic [CNT_W-1:0]   hits
);
    localparam int NBYTES = IVL_W / 8;
    localparam logic [CNT_W-1:0] HITS_MAX = '1;

    logic [IVL_W-1:0] elapsed_q;
    logic             active;
    logic             expire;

    assign active = (interval != '0);
    assign expire = tick && active &&
                    (({1'b0, elapsed_q} + (IVL_W+1)'(1)) >= {1'b0, interval});

    // Interval storage, byte-addressed, most significant byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= '0;
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (byte_we[b]) interval[IVL_W-1-8*b -: 8] <= wdata;
            end
        end
    end

    // Strobe counter: held at 0 when idle, reloads on expiration.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) elapsed_q <= '0;
        else if (expire)       elapsed_q <= '0;
        else if (tick)         elapsed_q <= elapsed_q + IVL_W'(1);
    end

    // Done flag: an expiration outranks a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (expire) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // Saturating expiration count; a clear that meets an expiration leaves 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                    hits <= '0;
        else if (clr && expire)        hits <= CNT_W'(1);
        else if (clr)                  hits <= '0;
        else if (expire && hits != HITS_MAX) hits <= hits + CNT_W'(1);
    end

    // R6: an idle timer never raises its flag.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0 && !flag && !clr) |=> !flag);
    // R5: the count stays at its ceiling.
    a_r5_hits_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (hits == HITS_MAX && !clr) |=> hits == HITS_MAX);
    // R7: a clear without a strobe empties the flag and the count.
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !tick) |=> (!flag && hits == '0));
    // R8: an expiration beats a simultaneous clear.
    a_r8_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && expire) |=> (flag && hits == CNT_W'(1)));
    // R4: each unsaturated expiration adds exactly one.
    a_r4_hits_step: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !clr && hits != HITS_MAX) |=> hits == $past(hits) + CNT_W'(1));
endmodule

// File: rtl/ms_timer_bank.sv
// Module: ms_timer_bank
// Top of the timer bank. It decodes the byte register port, holds the enable and
// clear registers, builds the clear strobes and the combined interrupt, and
// instantiates the prescaler and N_TMR channels.
// Assumes N_TMR <= 8, so each per-timer register fits in one byte.
module ms_timer_bank
    import mstb_pkg::*;
#(
    parameter int TICK_DIV = 125000,
    parameter int N_TMR    = 8,
    parameter int IVL_W    = 32,
    parameter int CNT_W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int IVL_BYTES = IVL_W / BYTE_W;
    localparam int CNT_BASE  = IVL_BASE + N_TMR * IVL_BYTES;

    logic                 tick;
    logic [N_TMR-1:0]     en_q;
    reg_byte_t            clr_q;
    logic [N_TMR-1:0]     clr_pulse;
    logic [N_TMR-1:0]     flags;
    logic [IVL_W-1:0]     ivl   [N_TMR];
    logic [CNT_W-1:0]     hits  [N_TMR];
    reg_byte_t            rd_mux;
    logic                 wr_clr;

    mstb_prescaler #(.TICK_DIV(TICK_DIV)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign wr_clr = wr_en && (int'(reg_addr) == ADDR_CLR);

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic [IVL_BYTES-1:0] byte_we;
        for (genvar b = 0; b < IVL_BYTES; b++) begin : g_byte
            assign byte_we[b] = wr_en &&
                (int'(reg_addr) == IVL_BASE + IVL_BYTES * i + b);
        end
        assign clr_pulse[i] = wr_clr && reg_wdata[i];

        mstb_channel #(.IVL_W(IVL_W), .CNT_W(CNT_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .clr      (clr_pulse[i]),
            .byte_we  (byte_we),
            .wdata    (reg_wdata),
            .interval (ivl[i]),
            .flag     (flags[i]),
            .hits     (hits[i])
        );
    end

    // Enable and clear registers; the clear register keeps what was written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            clr_q <= '0;
        end else if (wr_en) begin
            if (int'(reg_addr) == ADDR_EN) en_q  <= reg_wdata[N_TMR-1:0];
            if (wr_clr)                    clr_q <= reg_wdata;
        end
    end

    // Read multiplexer over the whole map; unmapped addresses give 0.
    always_comb begin
        rd_mux = '0;
        if (int'(reg_addr) == ADDR_EN)   rd_mux = BYTE_W'(en_q);
        if (int'(reg_addr) == ADDR_CLR)  rd_mux = clr_q;
        if (int'(reg_addr) == ADDR_FLAG) rd_mux = BYTE_W'(flags);
        for (int i = 0; i < N_TMR; i++) begin
            for (int b = 0; b < IVL_BYTES; b++) begin
                if (int'(reg_addr) == IVL_BASE + IVL_BYTES * i + b)
                    rd_mux = ivl[i][IVL_W-1-8*b -: 8];
            end
            if (int'(reg_addr) == CNT_BASE + i) rd_mux = BYTE_W'(hits[i]);
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // Combined interrupt.
    assign irq = |(flags & en_q);

    // R9: clearing every timer away from a strobe drops the interrupt next cycle.
    a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && reg_wdata == 8'hFF && !tick) |=> !irq);
    // R10: a write to the flag address never sets a flag without a strobe.
    a_r10_flag_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(reg_addr) == ADDR_FLAG && !tick) |=> (flags & ~$past(flags)) == '0);
    // R11: read data holds when no read is requested.
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_ms_timer_bank.sv
// Scoreboard bench: the driver pushes the expected read data into a queue and the
// monitor pops and compares it when the registered data arrives.
module test_ms_timer_bank;
    localparam int DIV = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int ecnt   = 0;
    logic pend_q = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    ms_timer_bank #(.TICK_DIV(DIV)) i_ms_timer_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    // Count edges since reset release; strobe edges are multiples of DIV.
    always @(posedge clk) begin
        if (rst_n) ecnt <= ecnt + 1;
        pend_q <= rd_en;
    end

    // Monitor: compare registered read data with the queued expectation.
    always @(negedge clk) begin
        if (pend_q) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input int a, input int d);
        reg_addr = 8'(a); reg_wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input int e, input string t);
        reg_addr = 8'(a); rd_en = 1'b1;
        exp_q.push_back(8'(e)); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    // Wait until two edges past the n-th strobe boundary from now.
    task automatic wait_ticks(input int n);
        int target;
        target = ((ecnt / DIV) + n) * DIV + 2;
        while (ecnt < target) @(negedge clk);
    endtask

    task automatic set_ivl(input int t, input int v);
        for (int b = 0; b < 4; b++) wr('h0A + 4 * t + b, (v >> (24 - 8 * b)) & 'hFF);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of the whole map
        chk_irq(1'b0, "R1 irq after reset");
        rd('h07, 0, "R1 enable"); rd('h08, 0, "R1 clear"); rd('h09, 0, "R1 flags");
        for (int a = 'h0A; a < 'h32; a++) rd(a, 0, "R1 interval/count byte");

        // R2: byte order of timer 8 interval, then zero it again
        wr('h26, 'hA1); wr('h27, 'hB2); wr('h28, 'hC3); wr('h29, 'hD4);
        rd('h26, 'hA1, "R2 t8 byte0"); rd('h27, 'hB2, "R2 t8 byte1");
        rd('h28, 'hC3, "R2 t8 byte2"); rd('h29, 'hD4, "R2 t8 byte3");
        rd('h31, 0, "R2 t8 count");
        set_ivl(7, 0);

        // R3: timer 1, interval 3
        wait_ticks(1);
        set_ivl(0, 3);
        wait_ticks(2);
        rd('h09, 'h00, "R3 flag not yet");
        wait_ticks(1);
        rd('h09, 'h01, "R3 flag on third strobe");
        rd('h2A, 1, "R3 count one");
        chk_irq(1'b0, "R9 irq masked");
        wr('h07, 'h01);
        chk_irq(1'b1, "R9 irq enabled");

        // R4: reload and count again
        wait_ticks(3);
        rd('h2A, 2, "R4 count two");

        // R7: clear through write of 1
        wr('h08, 'h01);
        chk_irq(1'b0, "R9 irq after clear");
        rd('h09, 'h00, "R7 flag cleared");
        rd('h2A, 0, "R7 count cleared");
        rd('h08, 'h01, "R7 clear reg holds");
        wait_ticks(3);
        rd('h09, 'h01, "R4 expires again");
        wr('h08, 'h01);
        rd('h09, 'h00, "R7 clear while bit already 1");
        wait_ticks(3);
        wr('h08, 'h00);
        rd('h09, 'h01, "R7 write 0 no effect");
        rd('h2A, 1, "R7 count kept");

        // R10: flag register and unmapped addresses ignore writes
        wr('h09, 'h00); wr('h40, 'hFF);
        rd('h09, 'h01, "R10 flag read-only");
        rd('h40, 0, "R2 unmapped 0x40"); rd('h00, 0, "R2 unmapped 0x00");
        rd('h32, 0, "R2 unmapped 0x32");

        // park timer 1
        set_ivl(0, 0); wr('h08, 'h01); wr('h07, 'h00);
        chk_irq(1'b0, "R9 irq after disable");

        // R5: timer 2 with interval 1 saturates
        wait_ticks(1);
        set_ivl(1, 1);
        wait_ticks(260);
        rd('h2B, 255, "R5 saturated count");
        rd('h09, 'h02, "R6 only timer 2 flagged");

        // R9: enable of an idle timer does not raise irq
        wr('h07, 'h04);
        chk_irq(1'b0, "R9 idle timer enabled");
        wr('h07, 'h02);
        chk_irq(1'b1, "R9 timer 2 enabled");

        // R8: clear meets an expiration on a strobe edge
        while ((ecnt % DIV) != DIV - 1) @(negedge clk);
        wr('h08, 'h02);
        rd('h09, 'h02, "R8 flag survives");
        rd('h2B, 1, "R8 count is one");
        chk_irq(1'b1, "R8 irq stays");

        // R6: timer 3 never expired
        rd('h2C, 0, "R6 idle count");
        // R11: data holds without a read strobe
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== 8'h00) begin
            fails++;
            $display("FAIL R11 hold: rd_data=%h expected=00", rd_data);
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule